// File: doc/BRIEF.md
# Port Statistics Counter Bank

This block keeps a set of 64-bit traffic statistics for every port of an Ethernet switch. A MAC that has already parsed each frame feeds the bank one-cycle event strobes together with the transmit and receive frame lengths. The bank turns those inputs into counts: frames, octets, cast type, errors, pause frames, VLAN tags and a receive frame-size histogram.

Software reads the counters over a plain 32-bit read port. A 64-bit value takes two reads. The first read, at the counter's own word address, returns the lower 32 bits. At that same moment it copies the upper 32 bits into one common upper-word register. The second read, at the common address, returns the copied upper half. Because of this, both halves describe the same instant, even while traffic keeps counting. Every port has the same counter layout, placed one fixed stride apart.

Top module: `port_stat_bank`

## Requirements
- R1: While reset is asserted and right after it, every counter and the common upper-word register read as zero, and no read response is issued during reset.
- R2: Within each port's slice of `evtStrobe` (port p owns bits p*17 to p*17+16), bit e is the increment strobe for counter e. Each cycle a bit is high adds exactly one to its counter. The bits are: 0 good tx frame, 1 good rx frame, 2 rx FCS error, 3 tx unicast, 4 tx multicast, 5 tx broadcast, 6 rx unicast, 7 rx multicast, 8 rx broadcast, 9 tx pause, 10 rx pause, 11 rx undersize, 12 rx oversize, 13 rx fragment, 14 rx jabber, 15 rx VLAN-tagged, 16 tx VLAN-tagged.
- R3: Counter 17 adds the port's `txLen` on every cycle in which bit 0 is high. Counter 18 adds `rxLen` on every cycle in which bit 1 is high.
- R4: On every cycle in which bit 1 is high, exactly one histogram counter increments, chosen by `rxLen`: 19 for 0 to 64, 20 for 65 to 127, 21 for 128 to 255, 22 for 256 to 511, 23 for 512 to 1023, 24 for 1024 to 1518, and 25 for 1519 and above.
- R5: A read issued with `rdEn` high at a clock edge is answered with `rdValid` high and its data after the next edge. `rdValid` is low in every cycle that does not follow a read.
- R6: Word address p*32+c holds the lower half of counter c of port p, for c from 0 to 25. The common upper-word register sits at word address 64.
- R7: A lower-half read copies the same counter's upper 32 bits into the common register. A read at address 64 returns the copied value and leaves it unchanged, so repeated upper reads agree until the next lower-half read.
- R8: When a counter increments in the same cycle as its lower-half read, the read returns the value from before the increment. The copied upper half belongs to that same value, and the increment is still kept.
- R9: Reads of unmapped addresses (counter slots 26 to 31, and addresses above 64) return zero and do not change the common register.
- R10: The counters are 64 bits wide. A carry out of the lower 32 bits shows up in the upper half returned through the common register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| evtStrobe | input | NUM_PORTS*17 | Per-port event strobes, laid out as in R2 |
| txLen | input | NUM_PORTS*LEN_W | Per-port transmit frame length, valid with the good tx strobe |
| rxLen | input | NUM_PORTS*LEN_W | Per-port receive frame length, valid with the good rx strobe |
| rdEn | input | 1 | Read request |
| rdAddr | input | ADDR_W | Word address of the read |
| rdValid | output | 1 | Read response valid, one cycle after `rdEn` |
| rdData | output | 32 | Read response data |

## Verification
The hardest case to reach from the ports is a carry out of the lower 32 bits arriving close to a lower-half read. That case is the one that shows whether the copied upper half stays matched to the returned lower half. Only the octet counters can climb that far in a short run. So the stimulus holds a good transmit strobe high with the largest length for a little over 65,536 cycles. During that burst it keeps reading the octet counter's lower half and then the common register. A random phase covers the other case: reads that land on counters as they increment, mixed with unmapped reads and repeated upper-half reads.

// File: rtl/port_stat_pkg.sv
package port_stat_pkg;
  localparam int IDX_W       = 5;
  localparam int PORT_STRIDE = 1 << IDX_W;
  localparam int NUM_EVT     = 17;
  localparam int EV_TX_GOOD  = 0;
  localparam int EV_RX_GOOD  = 1;
  localparam int NUM_BINS    = 7;
  localparam int IDX_TX_OCT  = NUM_EVT;
  localparam int IDX_RX_OCT  = NUM_EVT + 1;
  localparam int IDX_BIN0    = NUM_EVT + 2;
  localparam int NUM_CNT     = IDX_BIN0 + NUM_BINS;
  localparam int CNT_W       = 64;
  localparam int BUS_W       = 32;

  typedef struct packed {
    logic             loRd;
    logic             hiRd;
    logic             nullRd;
    logic [7:0]       port;
    logic [IDX_W-1:0] idx;
  } rdStrobe_t;

  // histogram bin for a received frame length
  function automatic int sizeBin(input int len);
    if (len <= 64)        return 0;
    else if (len <= 127)  return 1;
    else if (len <= 255)  return 2;
    else if (len <= 511)  return 3;
    else if (len <= 1023) return 4;
    else if (len <= 1518) return 5;
    else                  return 6;
  endfunction
endpackage

// File: rtl/port_stat_ctrl.sv
module port_stat_ctrl
  import port_stat_pkg::*;
#(
  parameter int NUM_PORTS = 2,
  parameter int ADDR_W    = 8
) (
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  output rdStrobe_t         strobe
);
  localparam int HI_ADDR = NUM_PORTS * PORT_STRIDE;

  logic [IDX_W-1:0] idxField;
  logic isHi, inBank, idxOk, loHit, hiHit;

  assign idxField = rdAddr[IDX_W-1:0];
  assign isHi     = (int'(rdAddr) == HI_ADDR);
  assign inBank   = (int'(rdAddr) < HI_ADDR);
  assign idxOk    = (int'(idxField) < NUM_CNT);
  assign loHit    = rdEn & inBank & idxOk;
  assign hiHit    = rdEn & isHi;

  always_comb begin
    strobe        = '0;
    strobe.port   = 8'(rdAddr >> IDX_W);
    strobe.idx    = idxField;
    strobe.loRd   = loHit;
    strobe.hiRd   = hiHit;
    strobe.nullRd = rdEn & ~loHit & ~hiHit;
  end
endmodule

// File: rtl/port_stat_datapath.sv
module port_stat_datapath
  import port_stat_pkg::*;
#(
  parameter int NUM_PORTS = 2,
  parameter int LEN_W     = 16
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [NUM_PORTS*NUM_EVT-1:0] evtStrobe,
  input  logic [NUM_PORTS*LEN_W-1:0] txLen,
  input  logic [NUM_PORTS*LEN_W-1:0] rxLen,
  input  rdStrobe_t                  strobe,
  output logic                       rdValid,
  output logic [BUS_W-1:0]           rdData
);
  localparam int TOTAL = NUM_PORTS * NUM_CNT;

  logic [TOTAL*CNT_W-1:0] cntFlat;
  logic [BUS_W-1:0]       hiWord;
  logic [CNT_W-1:0]       selVal;
  int                     selPos;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : port_g
    logic             txGood, rxGood;
    logic [LEN_W-1:0] txL, rxL;
    int               binSel;

    assign txGood = evtStrobe[p*NUM_EVT + EV_TX_GOOD];
    assign rxGood = evtStrobe[p*NUM_EVT + EV_RX_GOOD];
    assign txL    = txLen[p*LEN_W +: LEN_W];
    assign rxL    = rxLen[p*LEN_W +: LEN_W];
    always_comb binSel = sizeBin(int'(rxL));

    for (genvar c = 0; c < NUM_CNT; c++) begin : cnt_g
      logic [CNT_W-1:0] value, step;

      if (c < NUM_EVT) begin : ev_g
        assign step = CNT_W'(evtStrobe[p*NUM_EVT + c]);
      end else if (c == IDX_TX_OCT) begin : txo_g
        assign step = txGood ? CNT_W'(txL) : '0;
      end else if (c == IDX_RX_OCT) begin : rxo_g
        assign step = rxGood ? CNT_W'(rxL) : '0;
      end else begin : bin_g
        assign step = CNT_W'(rxGood && (binSel == (c - IDX_BIN0)));
      end

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) value <= '0;
        else       value <= value + step;
      end

      assign cntFlat[(p*NUM_CNT + c)*CNT_W +: CNT_W] = value;
    end
  end

  always_comb begin
    selPos = int'(strobe.port) * NUM_CNT + int'(strobe.idx);
    selVal = (selPos < TOTAL) ? cntFlat[selPos*CNT_W +: CNT_W] : '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdValid <= 1'b0;
      rdData  <= '0;
      hiWord  <= '0;
    end else begin
      rdValid <= strobe.loRd | strobe.hiRd | strobe.nullRd;
      if (strobe.loRd) begin
        rdData <= selVal[BUS_W-1:0];
        hiWord <= selVal[CNT_W-1:BUS_W];
      end else if (strobe.hiRd) begin
        rdData <= hiWord;
      end else begin
        rdData <= '0;
      end
    end
  end
endmodule

// File: rtl/port_stat_bank.sv
module port_stat_bank
  import port_stat_pkg::*;
#(
  parameter int NUM_PORTS = 2,
  parameter int LEN_W     = 16,
  parameter int ADDR_W    = 8
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [NUM_PORTS*NUM_EVT-1:0] evtStrobe,
  input  logic [NUM_PORTS*LEN_W-1:0]   txLen,
  input  logic [NUM_PORTS*LEN_W-1:0]   rxLen,
  input  logic                         rdEn,
  input  logic [ADDR_W-1:0]            rdAddr,
  output logic                         rdValid,
  output logic [BUS_W-1:0]             rdData
);
  rdStrobe_t strobe;

  port_stat_ctrl #(.NUM_PORTS(NUM_PORTS), .ADDR_W(ADDR_W)) ctrl_i (
    .rdEn   (rdEn),
    .rdAddr (rdAddr),
    .strobe (strobe)
  );

  port_stat_datapath #(.NUM_PORTS(NUM_PORTS), .LEN_W(LEN_W)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .evtStrobe (evtStrobe),
    .txLen     (txLen),
    .rxLen     (rxLen),
    .strobe    (strobe),
    .rdValid   (rdValid),
    .rdData    (rdData)
  );
endmodule

// File: rtl/port_stat_bank_chk.sv
module port_stat_bank_chk
  import port_stat_pkg::*;
#(
  parameter int NUM_PORTS = 2,
  parameter int ADDR_W    = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              rdEn,
  input logic [ADDR_W-1:0] rdAddr,
  input logic              rdValid,
  input logic [BUS_W-1:0]  rdData,
  input rdStrobe_t         strobe
);
  localparam int HI_ADDR = NUM_PORTS * PORT_STRIDE;

  logic isHiAddr, isLoAddr, isNull;
  logic hiIssued, haveHi;
  logic [BUS_W-1:0] lastHi;

  assign isHiAddr = (int'(rdAddr) == HI_ADDR);
  assign isLoAddr = (int'(rdAddr) < HI_ADDR) && (int'(rdAddr[IDX_W-1:0]) < NUM_CNT);
  assign isNull   = !isHiAddr && !isLoAddr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hiIssued <= 1'b0;
      haveHi   <= 1'b0;
      lastHi   <= '0;
    end else begin
      hiIssued <= rdEn && isHiAddr;
      if (rdValid && hiIssued) begin
        haveHi <= 1'b1;
        lastHi <= rdData;
      end
      if (rdEn && isLoAddr) haveHi <= 1'b0;
    end
  end

  // R5
  rd_valid_chk: assert property (@(posedge clk) disable iff (!rstN) rdEn |=> rdValid);
  // R5
  rd_idle_chk: assert property (@(posedge clk) disable iff (!rstN) !rdEn |=> !rdValid);
  // R6
  decode_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.loRd, strobe.hiRd, strobe.nullRd}));
  // R9
  null_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && isNull) |=> (rdData == '0));
  // R7
  hi_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid && hiIssued && haveHi) |-> (rdData == lastHi));
endmodule

bind port_stat_bank port_stat_bank_chk #(.NUM_PORTS(NUM_PORTS), .ADDR_W(ADDR_W)) chk_i (
  .clk     (clk),
  .rstN    (rstN),
  .rdEn    (rdEn),
  .rdAddr  (rdAddr),
  .rdValid (rdValid),
  .rdData  (rdData),
  .strobe  (strobe)
);

// File: tb/port_stat_bank_tb_top.sv
module port_stat_bank_tb_top;
  localparam int P  = 2;
  localparam int NE = 17;
  localparam int NC = 26;
  localparam int LW = 16;
  localparam int AW = 8;
  localparam int HI = 64;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic            rstN;
  logic [P*NE-1:0] evt;
  logic [P*LW-1:0] txLen, rxLen;
  logic            rdEn;
  logic [AW-1:0]   rdAddr;
  logic            rdValid;
  logic [31:0]     rdData;

  port_stat_bank #(.NUM_PORTS(P), .LEN_W(LW), .ADDR_W(AW)) dut_i (
    .clk(clk), .rstN(rstN), .evtStrobe(evt), .txLen(txLen), .rxLen(rxLen),
    .rdEn(rdEn), .rdAddr(rdAddr), .rdValid(rdValid), .rdData(rdData)
  );

  logic [63:0] refCnt [P][NC];
  logic [31:0] refHi;
  logic [31:0] expQ[$];
  string       tagQ[$];
  int errors = 0;
  int checks = 0;
  string phase = "reset";
  bit running = 0;

  function automatic int binOf(int len);
    int bounds[6] = '{64, 127, 255, 511, 1023, 1518};
    for (int i = 0; i < 6; i++) if (len <= bounds[i]) return i;
    return 6;
  endfunction

  function automatic logic [63:0] incOf(int p, int c);
    int tl = int'(txLen[p*LW +: LW]);
    int rl = int'(rxLen[p*LW +: LW]);
    if (c < NE) return 64'(evt[p*NE + c]);
    if (c == 17) return evt[p*NE] ? 64'(tl) : 64'd0;
    if (c == 18) return evt[p*NE + 1] ? 64'(rl) : 64'd0;
    return (evt[p*NE + 1] && binOf(rl) == c - 19) ? 64'd1 : 64'd0;
  endfunction

  // behavioural reference model, updated on every rising edge
  always @(posedge clk) begin
    int a, p, c;
    logic [31:0] e;
    string t;
    if (!rstN) begin
      for (int i = 0; i < P; i++) for (int j = 0; j < NC; j++) refCnt[i][j] = '0;
      refHi = '0;
      expQ.delete();
      tagQ.delete();
    end else begin
      if (rdEn) begin
        a = int'(rdAddr);
        if (a == HI) begin
          e = refHi; t = "R7";
        end else if (a < HI && (a % 32) < NC) begin
          p = a / 32; c = a % 32;
          e = refCnt[p][c][31:0];
          refHi = refCnt[p][c][63:32];
          t = (c < NE) ? "R2" : (c < 19) ? "R3" : "R4";
          if (p > 0) t = {t, " R6"};
          if (incOf(p, c) != 0) t = {t, " R8"};
        end else begin
          e = '0; t = "R9";
        end
        if (phase == "reset") t = {t, " R1"};
        if (phase == "carry") t = {t, " R10"};
        expQ.push_back(e);
        tagQ.push_back(t);
      end
      for (int i = 0; i < P; i++)
        for (int j = 0; j < NC; j++) refCnt[i][j] = refCnt[i][j] + incOf(i, j);
    end
  end

  // compare away from the active edge
  always @(negedge clk) begin
    logic [31:0] e;
    string t;
    if (rstN && running) begin
      checks++;
      if (rdValid !== (expQ.size() > 0)) begin
        errors++;
        $display("FAIL R5 rdValid actual=%0b expected=%0b", rdValid, expQ.size() > 0);
      end
      if (expQ.size() > 0) begin
        e = expQ.pop_front();
        t = tagQ.pop_front();
        checks++;
        if (rdData !== e) begin
          errors++;
          $display("FAIL %s read data actual=%h expected=%h", t, rdData, e);
        end
      end
    end
  end

  function automatic int pickLen();
    int corners[14] = '{0, 63, 64, 65, 127, 128, 255, 256, 511, 512, 1023, 1024, 1518, 1519};
    if ($urandom_range(3) == 0) return int'($urandom_range(65535));
    return corners[$urandom_range(13)];
  endfunction

  initial begin
    rstN = 1'b0; evt = '0; txLen = '0; rxLen = '0; rdEn = 1'b0; rdAddr = '0;
    repeat (5) @(negedge clk);
    // R1: outputs quiet in reset
    checks++;
    if (rdValid !== 1'b0 || rdData !== 32'd0) begin
      errors++;
      $display("FAIL R1 reset outputs actual=%0b/%h expected=0/0", rdValid, rdData);
    end
    rstN = 1'b1;
    running = 1;
    // R1: every counter and the upper register read zero
    for (int pp = 0; pp < P; pp++)
      for (int cc = 0; cc < NC; cc++) begin
        @(negedge clk); rdEn = 1'b1; rdAddr = AW'(pp*32 + cc);
        @(negedge clk); rdAddr = AW'(HI);
      end
    @(negedge clk); rdEn = 1'b0;
    @(negedge clk);
    phase = "mix";
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      for (int b = 0; b < P*NE; b++) evt[b] = ($urandom_range(3) == 0);
      for (int pp = 0; pp < P; pp++) begin
        txLen[pp*LW +: LW] = LW'(pickLen());
        rxLen[pp*LW +: LW] = LW'(pickLen());
      end
      rdEn = ($urandom_range(1) == 1);
      case ($urandom_range(7))
        0, 1:    rdAddr = AW'(HI);
        2:       rdAddr = AW'($urandom_range(95));
        default: rdAddr = AW'($urandom_range(P-1)*32 + $urandom_range(NC-1));
      endcase
    end
    @(negedge clk); evt = '0; rdEn = 1'b0;
    @(negedge clk);
    phase = "carry";
    evt[0] = 1'b1;
    txLen[LW-1:0] = '1;
    for (int i = 0; i < 66000; i++) begin
      @(negedge clk);
      rdEn = (i % 8) < 3;
      rdAddr = ((i % 8) == 0) ? AW'(17) : AW'(HI);
    end
    @(negedge clk); evt = '0; rdEn = 1'b0;
    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule